// File: doc/BRIEF.md
# Sequential Byte Multiply/Divide Unit

This unit takes two unsigned bytes, a primary operand and a secondary operand, and either multiplies or divides them. The work is done over several clock cycles, one bit per cycle. Multiply uses shift-and-add. Divide uses restoring shift-and-subtract. A one-cycle start request launches an operation. The unit reports busy while it iterates, then pulses done for one cycle.

The two result bytes come back split across two outputs, in the manner of an accumulator paired with a helper register. For multiply, the low product byte goes to the primary output and the high byte to the secondary output. For divide, the quotient goes to the primary output and the remainder to the secondary output. A carry flag and an overflow flag come with the results. Carry is always cleared. Overflow means a product that does not fit one byte, or, for divide, a zero divisor. Results and flags are registered and stay put between completions.

Top module: `mdu8_seq`

## Requirements
- R1: While reset is asserted and after its release, busy, done, both result bytes, the carry flag and the overflow flag are all 0 until the first operation completes.
- R2: With op_div = 0 (multiply), the 16-bit product a_in*b_in appears with its low byte on a_out and its high byte on b_out; 0xFF times 0xFF yields b_out = 0xFE and a_out = 0x01.
- R3: After a multiply, cy_out is 0 and ov_out is 1 exactly when the product exceeds 0xFF.
- R4: With op_div = 1 (divide) and a non-zero divisor, a_out holds the integer quotient a_in/b_in, b_out holds the remainder, and cy_out and ov_out are both 0.
- R5: A divide with b_in = 0 still completes with a done pulse at the normal time; ov_out is 1, cy_out is 0, a_out returns the original a_in and b_out returns 0x00.
- R6: A start seen at a clock edge while busy is low is accepted. busy is high for the next 8 cycles. done is high for exactly the one cycle that follows, with busy low in that cycle.
- R7: A start raised while busy is high is ignored; neither its operands nor its operation select alter the running operation's results or timing.
- R8: a_out, b_out, cy_out and ov_out change only at the edge that raises done, and hold their values in every other cycle.
- R9: A start raised in the same cycle that done is high is accepted, so operations run back to back with one done cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, sampled while idle |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| a_in | input | 8 | Primary operand (multiplicand / dividend) |
| b_in | input | 8 | Secondary operand (multiplier / divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| a_out | output | 8 | Product low byte or quotient |
| b_out | output | 8 | Product high byte or remainder |
| cy_out | output | 1 | Carry flag, always cleared on completion |
| ov_out | output | 1 | Product above 0xFF, or divide by zero |

## Verification
Two events can land in the same cycle: the completion of one operation, with done high, and the acceptance of the next start. A start held high across a busy window is also presented at the same edge that finishes the current operation. The bench provokes both with directed back-to-back requests and with randomly timed ones. A behavioural reference updates its idle, busy and done state from the start line at every edge. The outputs are compared against it on every clock, so a start that is taken one cycle early or late, or that is lost at the done boundary, shows up as a busy, done or result miscompare.

// File: rtl/mdu8_pkg.sv
package mdu8_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } mdu_op_e;
endpackage

// File: rtl/mdu8_ctrl.sv
module mdu8_ctrl #(
  parameter int STEPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(STEPS + 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // next state
  always_comb begin
    load   = start & ~busy_q;
    step   = busy_q;
    last   = busy_q && (cnt_q == CW'(STEPS - 1));
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = last;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + CW'(1);
      if (last) busy_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_accept_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q);
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && !done_q));
  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(busy_q) && !busy_q));
endmodule

// File: rtl/mdu8_step.sv
module mdu8_step #(
  parameter int W = 8
) (
  input  logic         is_div,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] hi_n,
  output logic [W-1:0] lo_n
);
  logic [W:0]   msum;
  logic [W:0]   dsh;
  logic [W:0]   ddif;
  logic         fits;

  always_comb begin
    // multiply: conditional add of the multiplier, then shift right
    msum = {1'b0, hi} + (lo[0] ? {1'b0, opnd} : '0);
    // divide: shift the partial remainder left, trial subtract
    dsh  = {hi, lo[W-1]};
    ddif = dsh - {1'b0, opnd};
    fits = (dsh >= {1'b0, opnd});
    if (is_div) begin
      hi_n = fits ? ddif[W-1:0] : dsh[W-1:0];
      lo_n = {lo[W-2:0], fits};
    end else begin
      hi_n = msum[W:1];
      lo_n = {msum[0], lo[W-1:1]};
    end
  end
endmodule

// File: rtl/mdu8_seq.sv
module mdu8_seq
  import mdu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_div,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         cy_out,
  output logic         ov_out
);
  logic         load, step, last;
  mdu_op_e      op_q, op_d;
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d, m_q, m_d, keep_q, keep_d;
  logic [W-1:0] hi_n, lo_n;
  logic [W-1:0] ra_q, ra_d, rb_q, rb_d;
  logic         cy_q, cy_d, ov_q, ov_d;

  mdu8_ctrl #(.STEPS(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .step(step), .last(last), .busy(busy), .done(done)
  );

  mdu8_step #(.W(W)) u_step (
    .is_div(op_q == OP_DIV), .hi(hi_q), .lo(lo_q), .opnd(m_q),
    .hi_n(hi_n), .lo_n(lo_n)
  );

  // working registers: next state
  always_comb begin
    op_d   = op_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    m_d    = m_q;
    keep_d = keep_q;
    if (load) begin
      op_d   = op_div ? OP_DIV : OP_MUL;
      hi_d   = '0;
      lo_d   = a_in;
      m_d    = b_in;
      keep_d = a_in;
    end else if (step) begin
      hi_d = hi_n;
      lo_d = lo_n;
    end
  end

  // result registers: next state, written only on the final step
  always_comb begin
    ra_d = ra_q;
    rb_d = rb_q;
    cy_d = cy_q;
    ov_d = ov_q;
    if (last) begin
      cy_d = 1'b0;
      if (op_q == OP_MUL) begin
        ra_d = lo_n;
        rb_d = hi_n;
        ov_d = |hi_n;
      end else if (m_q == '0) begin
        ra_d = keep_q;
        rb_d = m_q;
        ov_d = 1'b1;
      end else begin
        ra_d = lo_n;
        rb_d = hi_n;
        ov_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_MUL;
      hi_q   <= '0;
      lo_q   <= '0;
      m_q    <= '0;
      keep_q <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
      cy_q   <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      op_q   <= op_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      m_q    <= m_d;
      keep_q <= keep_d;
      ra_q   <= ra_d;
      rb_q   <= rb_d;
      cy_q   <= cy_d;
      ov_q   <= ov_d;
    end
  end

  assign a_out  = ra_q;
  assign b_out  = rb_q;
  assign cy_out = cy_q;
  assign ov_out = ov_q;

  p_hold_results_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(a_out) && $stable(b_out) && $stable(cy_out) && $stable(ov_out)));
  p_mul_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_MUL) |-> (ov_out == (b_out != '0)));
  p_div_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_DIV && m_q == '0) |-> (ov_out && a_out == keep_q && b_out == '0));
  p_div_remainder_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_DIV && m_q != '0) |-> (b_out < m_q && !ov_out));
endmodule

// File: tb/sim_mdu8_seq.sv
module sim_mdu8_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       op_div = 1'b0;
  logic [7:0] a_in = 8'h00;
  logic [7:0] b_in = 8'h00;
  logic       busy, done, cy_out, ov_out;
  logic [7:0] a_out, b_out;

  int n_vec = 0;
  int n_bad = 0;
  bit ended = 0;

  always #4 clk = ~clk; // 125 MHz

  mdu8_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .a_in(a_in), .b_in(b_in), .busy(busy), .done(done),
    .a_out(a_out), .b_out(b_out), .cy_out(cy_out), .ov_out(ov_out)
  );

  // behavioural reference, updated at every edge
  bit     m_busy, m_done, m_op, m_cy, m_ov;
  int     m_cnt, m_a, m_b, m_ra, m_rb;

  task automatic expect_of(input bit dv, input int a, input int b,
                           output int ra, output int rb, output bit ov);
    if (!dv) begin
      ra = (a * b) % 256; rb = (a * b) / 256; ov = (a * b) > 255;
    end else if (b == 0) begin
      ra = a; rb = 0; ov = 1;
    end else begin
      ra = a / b; rb = a % b; ov = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_op = 0;
      m_a = 0; m_b = 0; m_ra = 0; m_rb = 0; m_cy = 0; m_ov = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 8) begin
          m_busy = 0; m_done = 1; m_cy = 0;
          expect_of(m_op, m_a, m_b, m_ra, m_rb, m_ov);
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0; m_op = op_div; m_a = a_in; m_b = b_in;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      string rq;
      check("R6", "busy", busy, m_busy);
      check("R6", "done", done, m_done);
      rq = !m_op ? "R2" : (m_b == 0 ? "R5" : "R4");
      check(rq, "a_out", a_out, m_ra);
      check(rq, "b_out", b_out, m_rb);
      check(!m_op ? "R3" : rq, "cy_out", cy_out, m_cy);
      check(!m_op ? "R3" : rq, "ov_out", ov_out, m_ov);
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic issue(input bit dv, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    start = 1; op_div = dv; a_in = a; b_in = b;
    @(negedge clk);
    start = 0; a_in = 8'h5A; b_in = 8'hA5; op_div = ~dv;
  endtask

  // wait until the negedge where done is high
  task automatic wait_done();
    for (int i = 0; i < 20 && !done; i++) @(negedge clk);
  endtask

  task automatic run_check(input string req, input bit dv, input logic [7:0] a, input logic [7:0] b);
    int ra, rb; bit ov;
    issue(dv, a, b);
    wait_done();
    expect_of(dv, a, b, ra, rb, ov);
    check(req, "done seen", done, 1);
    check(req, "a_out", a_out, ra);
    check(req, "b_out", b_out, rb);
    check(req, "ov_out", ov_out, ov);
    check(req, "cy_out", cy_out, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lat;
    logic [7:0] ha, hb;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", "busy in reset", busy, 0);
    check("R1", "done in reset", done, 0);
    check("R1", "a_out in reset", a_out, 0);
    check("R1", "b_out in reset", b_out, 0);
    check("R1", "flags in reset", {cy_out, ov_out}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1", "a_out after release", a_out, 0);
    check("R1", "ov_out after release", ov_out, 0);

    run_check("R2", 0, 8'hFF, 8'hFF);
    check("R2", "FF*FF high", b_out, 8'hFE);
    check("R2", "FF*FF low", a_out, 8'h01);
    run_check("R3", 0, 8'd3, 8'd5);
    run_check("R3", 0, 8'h10, 8'h10);
    run_check("R3", 0, 8'h00, 8'hC7);
    run_check("R4", 1, 8'd200, 8'd7);
    run_check("R4", 1, 8'd5, 8'd9);
    run_check("R4", 1, 8'hFF, 8'h01);
    run_check("R5", 1, 8'h37, 8'h00);

    // R6 latency: count busy cycles after the start edge
    @(negedge clk);
    start = 1; op_div = 0; a_in = 8'd9; b_in = 8'd9;
    @(negedge clk);
    start = 0;
    lat = 0;
    while (busy && lat < 20) begin lat++; @(negedge clk); end
    check("R6", "busy cycle count", lat, 8);
    check("R6", "done after busy", done, 1);

    // R7: start with other operands while busy is ignored
    issue(0, 8'd12, 8'd11);
    repeat (2) @(negedge clk);
    start = 1; op_div = 1; a_in = 8'd0; b_in = 8'd0;
    @(negedge clk);
    start = 0;
    wait_done();
    check("R7", "a_out ignores busy start", a_out, (12 * 11) % 256);
    check("R7", "ov_out ignores busy start", ov_out, 0);

    // R8: results hold with inputs wiggling and no start
    ha = a_out; hb = b_out;
    for (int i = 0; i < 6; i++) begin
      a_in = 8'(i * 37); b_in = 8'(i * 13); op_div = i[0];
      @(negedge clk);
    end
    check("R8", "a_out held", a_out, ha);
    check("R8", "b_out held", b_out, hb);

    // R9: start in the done cycle is accepted
    issue(1, 8'd100, 8'd3);
    wait_done();
    start = 1; op_div = 0; a_in = 8'd20; b_in = 8'd20;
    @(negedge clk);
    start = 0;
    check("R9", "busy after done-cycle start", busy, 1);
    wait_done();
    check("R9", "back-to-back low byte", a_out, 8'h90);
    check("R9", "back-to-back high byte", b_out, 8'h01);

    // random traffic: start at arbitrary times, often while busy
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      start  = ($urandom_range(0, 3) == 0);
      op_div = $urandom_range(0, 1);
      a_in   = 8'($urandom_range(0, 255));
      b_in   = ($urandom_range(0, 7) == 0) ? 8'h00 : 8'($urandom_range(0, 255));
    end
    @(negedge clk);
    start = 0;
    repeat (12) @(negedge clk);
    finish_run();
  end
endmodule